// File: doc/BRIEF.md
# Relocatable Peripheral Window Decoder

This block decodes a movable 4 KB window for on-chip peripherals on a bus with 24 address bits and a 3-bit function code. Software places the window by writing a 16-bit base register. That register sits at a fixed word address (0x0F2) and is reachable only in supervisor data space (function code 5). The decoder flags every bus cycle that falls in the window. It raises an internal-access indication for window hits and for its own register locations. It also holds off external chip selects while the register locations are being accessed.

The window stays closed after power-up until software has programmed the base register. On an 8-bit bus, the window opens only when the low byte has been written. A word write on such a bus arrives as the high byte first and then the low byte. External devices that answer inside the window are reported as decode conflicts. Such a conflict sets a sticky flag and, if enabled, asserts a bus error.

A companion control word at 0x0F4 (same space) holds the conflict enable and the sticky conflict flag. The block's register state is cleared only by a total reset, which is the reset and halt inputs high together on a clock edge. Reset alone leaves the register state alone.

Top module: `pbase_decoder`

## Requirements
- R1: When `rst_in` and `halt_in` are both high on a clock edge, the base register becomes 0xBFFF, the control word becomes 0 and the window is closed. When `rst_in` is high with `halt_in` low, the register contents and the open/closed state are unchanged.
- R2: With function code 5 and address bits 23..1 equal to 0x0F2>>1, reads return the base register on `bus_rdata`. Writes update byte [15:8] when `bus_be_hi` is set and byte [7:0] when `bus_be_lo` is set. With any other function code, the access neither changes the register nor returns data; `bus_rdata` is 0 whenever no register is read.
- R3: Base register bits 11..0 hold the window base. A cycle with `bus_valid` high and `bus_addr[23:12]` equal to that field produces `win_hit`. Bits 11..0 of the address do not matter.
- R4: When base register bit 12 is 1, a hit also requires `bus_fc` to equal register bits 15..13. When bit 12 is 0, `bus_fc` is not compared.
- R5: A cycle with `bus_fc` = 7 never produces `win_hit`, whatever is programmed.
- R6: `win_hit` stays low until the base register is written. With `narrow_bus` = 0, any write opens the window. With `narrow_bus` = 1, only a write with `bus_be_lo` set opens it.
- R7: `int_access` is high for every window hit and for every supervisor-data access to 0x0F2 or 0x0F4. `cs_inhibit` is high for those register accesses and low for window hits elsewhere.
- R8: Control word bit 0 is the conflict flag. A clock edge with `win_hit` and `ext_sel` both high sets it, and it then stays set. A write to 0x0F4 with `bus_be_lo` set and data bit 0 = 1 clears it. A new conflict in the same cycle wins over the clear.
- R9: Control word bit 1 is the conflict enable, written through `bus_be_lo`. `bus_err` is high exactly when `win_hit` and `ext_sel` are both high and the enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_in | input | 1 | Reset line; clears state only together with `halt_in` |
| halt_in | input | 1 | Halt line; combined with `rst_in` for total reset |
| narrow_bus | input | 1 | 1 selects 8-bit bus sequencing for opening the window |
| bus_valid | input | 1 | Bus cycle in progress |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_be_hi | input | 1 | Upper byte lane enable |
| bus_be_lo | input | 1 | Lower byte lane enable |
| bus_addr | input | 24 | Byte address |
| bus_fc | input | 3 | Function code of the cycle |
| bus_wdata | input | 16 | Write data |
| ext_sel | input | 1 | An external device is selected for this cycle |
| bus_rdata | output | 16 | Read data from the register locations, 0 otherwise |
| win_hit | output | 1 | Cycle falls inside the peripheral window |
| int_access | output | 1 | Cycle is served internally |
| cs_inhibit | output | 1 | Suppress external chip selects |
| bus_err | output | 1 | Bus error on an enabled decode conflict |

## Verification
Corrupted base register or open/closed state shows up on `win_hit` in the same cycle as the next probe cycle. It also shows up on `bus_rdata` as soon as the register is read back, so each scenario reads the register and then probes addresses just inside and just outside the window. A wrong conflict flag is visible only when the control word is next read, one cycle after the event at the earliest. A wrong enable shows up at once on `bus_err` during the next conflicting cycle. The reset-alone case and the user-space write are each followed by a read and a probe, so a lost or altered register is seen within two bus cycles.

// File: rtl/pbase_pkg.sv
package pbase_pkg;
    localparam int ADDR_W = 24;
    localparam int FC_W   = 3;
    localparam int DATA_W = 16;
    localparam int PAGE_W = 12;
    localparam int BASE_W = ADDR_W - PAGE_W;

    localparam logic [ADDR_W-1:0] BAR_LOC     = 24'h0000F2;
    localparam logic [ADDR_W-1:0] CTL_LOC     = 24'h0000F4;
    localparam logic [FC_W-1:0]   FC_SUP_DATA = 3'd5;
    localparam logic [FC_W-1:0]   FC_IACK     = 3'd7;
    localparam logic [DATA_W-1:0] BAR_RESET   = 16'hBFFF;

    typedef struct packed {
        logic [FC_W-1:0]   space;
        logic              fc_cmp;
        logic [BASE_W-1:0] base;
    } bar_t;

    typedef struct packed {
        logic              valid;
        logic              rnw;
        logic              hi;
        logic              lo;
        logic [ADDR_W-1:0] addr;
        logic [FC_W-1:0]   fc;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    typedef enum logic [1:0] {SEL_NONE, SEL_BAR, SEL_CTL} sel_e;

    function automatic logic [DATA_W-1:0] lane_merge(
        input logic [DATA_W-1:0] cur,
        input logic [DATA_W-1:0] nxt,
        input logic              hi,
        input logic              lo
    );
        logic [DATA_W-1:0] r;
        r = cur;
        if (hi) r[DATA_W-1:DATA_W/2] = nxt[DATA_W-1:DATA_W/2];
        if (lo) r[DATA_W/2-1:0]      = nxt[DATA_W/2-1:0];
        return r;
    endfunction
endpackage

// File: rtl/pbase_sysdec.sv
module pbase_sysdec
    import pbase_pkg::*;
(
    input  bus_req_t req,
    output sel_e     sel
);
    logic in_sup;
    logic unused_bit0;

    assign in_sup      = req.valid && (req.fc == FC_SUP_DATA);
    assign unused_bit0 = req.addr[0];

    always_comb begin
        sel = SEL_NONE;
        if (in_sup && (req.addr[ADDR_W-1:1] == BAR_LOC[ADDR_W-1:1]))
            sel = SEL_BAR;
        else if (in_sup && (req.addr[ADDR_W-1:1] == CTL_LOC[ADDR_W-1:1]))
            sel = SEL_CTL;
    end
endmodule

// File: rtl/pbase_regs.sv
module pbase_regs
    import pbase_pkg::*;
(
    input  logic              clk,
    input  logic              total_rst,
    input  logic              narrow_bus,
    input  bus_req_t          req,
    input  sel_e              sel,
    input  logic              conflict,
    output bar_t              bar,
    output logic              armed,
    output logic              conflict_en,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] bar_q;
    logic              armed_q, flag_q, en_q;
    logic              wr_bar, wr_ctl, clr_req;

    assign wr_bar  = (sel == SEL_BAR) && !req.rnw;
    assign wr_ctl  = (sel == SEL_CTL) && !req.rnw && req.lo;
    assign clr_req = wr_ctl && req.wdata[0];

    always_ff @(posedge clk) begin
        if (total_rst) begin
            bar_q   <= BAR_RESET;
            armed_q <= 1'b0;
            flag_q  <= 1'b0;
            en_q    <= 1'b0;
        end else begin
            if (wr_bar) begin
                bar_q <= lane_merge(bar_q, req.wdata, req.hi, req.lo);
                if (!narrow_bus || req.lo)
                    armed_q <= 1'b1;
            end
            if (wr_ctl)
                en_q <= req.wdata[1];
            if (conflict)
                flag_q <= 1'b1;
            else if (clr_req)
                flag_q <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        if (req.rnw) begin
            if (sel == SEL_BAR)
                rdata = bar_q;
            else if (sel == SEL_CTL)
                rdata = {{(DATA_W-2){1'b0}}, en_q, flag_q};
        end
    end

    assign bar         = bar_t'(bar_q);
    assign armed       = armed_q;
    assign conflict_en = en_q;

    // R1
    rst_value_chk: assert property (@(posedge clk)
        total_rst |=> (bar_q == BAR_RESET && !armed_q && !flag_q && !en_q));
    // R2
    bar_hold_chk: assert property (@(posedge clk) disable iff (total_rst)
        !wr_bar |=> $stable(bar_q));
    // R8
    flag_set_chk: assert property (@(posedge clk) disable iff (total_rst)
        conflict |=> flag_q);
    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (total_rst)
        (flag_q && !clr_req) |=> flag_q);
endmodule

// File: rtl/pbase_match.sv
module pbase_match
    import pbase_pkg::*;
(
    input  logic     clk,
    input  logic     total_rst,
    input  bus_req_t req,
    input  bar_t     bar,
    input  logic     armed,
    output logic     hit
);
    logic base_eq, space_ok, legal_fc;
    logic unused_low;

    assign base_eq    = req.addr[ADDR_W-1:PAGE_W] == bar.base;
    assign space_ok   = !bar.fc_cmp || (req.fc == bar.space);
    assign legal_fc   = req.fc != FC_IACK;
    assign unused_low = ^req.addr[PAGE_W-1:0];
    assign hit        = req.valid && armed && legal_fc && base_eq && space_ok;

    // R5
    iack_nohit_chk: assert property (@(posedge clk) disable iff (total_rst)
        (req.fc == FC_IACK) |-> !hit);
    // R6
    closed_nohit_chk: assert property (@(posedge clk) disable iff (total_rst)
        !armed |-> !hit);
endmodule

// File: rtl/pbase_decoder.sv
module pbase_decoder
    import pbase_pkg::*;
(
    input  logic              clk,
    input  logic              rst_in,
    input  logic              halt_in,
    input  logic              narrow_bus,
    input  logic              bus_valid,
    input  logic              bus_rnw,
    input  logic              bus_be_hi,
    input  logic              bus_be_lo,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [FC_W-1:0]   bus_fc,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              ext_sel,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              win_hit,
    output logic              int_access,
    output logic              cs_inhibit,
    output logic              bus_err
);
    bus_req_t req;
    sel_e     sel;
    bar_t     bar;
    logic     total_rst, armed, conflict_en, conflict;

    assign total_rst = rst_in && halt_in;
    assign req = '{valid: bus_valid, rnw: bus_rnw, hi: bus_be_hi, lo: bus_be_lo,
                   addr: bus_addr, fc: bus_fc, wdata: bus_wdata};

    pbase_sysdec u_sysdec (.req(req), .sel(sel));

    pbase_match u_match (
        .clk(clk), .total_rst(total_rst), .req(req),
        .bar(bar), .armed(armed), .hit(win_hit)
    );

    assign conflict = win_hit && ext_sel;

    pbase_regs u_regs (
        .clk(clk), .total_rst(total_rst), .narrow_bus(narrow_bus),
        .req(req), .sel(sel), .conflict(conflict),
        .bar(bar), .armed(armed), .conflict_en(conflict_en), .rdata(bus_rdata)
    );

    assign cs_inhibit = sel != SEL_NONE;
    assign int_access = win_hit || cs_inhibit;
    assign bus_err    = conflict && conflict_en;

    // R7
    inhibit_iac_chk: assert property (@(posedge clk) disable iff (total_rst)
        cs_inhibit |-> int_access);
    // R9
    berr_cause_chk: assert property (@(posedge clk) disable iff (total_rst)
        bus_err |-> (win_hit && ext_sel));
endmodule

// File: tb/pbase_decoder_test.sv
`timescale 1ns/100ps
module pbase_decoder_test;
    logic        clk = 1'b0;
    logic        rst_in = 1'b0, halt_in = 1'b0, narrow_bus = 1'b0;
    logic        bus_valid = 1'b0, bus_rnw = 1'b1, bus_be_hi = 1'b0, bus_be_lo = 1'b0;
    logic [23:0] bus_addr = '0;
    logic [2:0]  bus_fc = '0;
    logic [15:0] bus_wdata = '0;
    logic        ext_sel = 1'b0;
    logic [15:0] bus_rdata;
    logic        win_hit, int_access, cs_inhibit, bus_err;
    int total = 0, bad = 0;

    always #2.5 clk = ~clk;

    pbase_decoder uut (
        .clk(clk), .rst_in(rst_in), .halt_in(halt_in), .narrow_bus(narrow_bus),
        .bus_valid(bus_valid), .bus_rnw(bus_rnw), .bus_be_hi(bus_be_hi),
        .bus_be_lo(bus_be_lo), .bus_addr(bus_addr), .bus_fc(bus_fc),
        .bus_wdata(bus_wdata), .ext_sel(ext_sel), .bus_rdata(bus_rdata),
        .win_hit(win_hit), .int_access(int_access), .cs_inhibit(cs_inhibit),
        .bus_err(bus_err)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        bus_valid = 1'b0; bus_rnw = 1'b1; bus_be_hi = 1'b0; bus_be_lo = 1'b0;
        ext_sel = 1'b0; rst_in = 1'b0; halt_in = 1'b0;
    endtask

    task automatic wr(input logic [23:0] a, input logic [2:0] fc, input logic [15:0] d,
                      input logic hi, input logic lo);
        @(negedge clk);
        bus_valid = 1'b1; bus_rnw = 1'b0; bus_addr = a; bus_fc = fc;
        bus_wdata = d; bus_be_hi = hi; bus_be_lo = lo;
        @(posedge clk);
        idle();
    endtask

    task automatic rd(input logic [23:0] a, input logic [2:0] fc, output logic [15:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_rnw = 1'b1; bus_addr = a; bus_fc = fc;
        bus_be_hi = 1'b1; bus_be_lo = 1'b1;
        #1 d = bus_rdata;
        idle();
    endtask

    task automatic probe(input logic [23:0] a, input logic [2:0] fc, input logic ext,
                         output logic hit, output logic iac, output logic err);
        @(negedge clk);
        bus_valid = 1'b1; bus_rnw = 1'b1; bus_addr = a; bus_fc = fc; ext_sel = ext;
        #1 hit = win_hit; iac = int_access; err = bus_err;
        @(posedge clk);
        idle();
    endtask

    task automatic total_reset();
        @(negedge clk);
        rst_in = 1'b1; halt_in = 1'b1;
        @(posedge clk);
        idle();
    endtask

    task automatic t_reset();
        logic [15:0] d; logic h, i, e;
        total_reset();
        rd(24'h0000F2, 3'd5, d);  check("R1 bar reset value", d, 16'hBFFF);
        rd(24'h0000F4, 3'd5, d);  check("R1 ctl reset value", d, 16'h0000);
        probe(24'hFFF010, 3'd5, 1'b0, h, i, e);
        check("R6 closed before write", {15'b0, h}, 16'd0);
    endtask

    task automatic t_wide();
        logic [15:0] d; logic h, i, e;
        narrow_bus = 1'b0;
        wr(24'h0000F2, 3'd5, 16'hB123, 1'b1, 1'b1);
        rd(24'h0000F2, 3'd5, d);  check("R2 readback", d, 16'hB123);
        probe(24'h123ABC, 3'd5, 1'b0, h, i, e);
        check("R3 hit inside", {15'b0, h}, 16'd1);
        check("R7 iac on hit", {15'b0, i}, 16'd1);
        probe(24'h124000, 3'd5, 1'b0, h, i, e);
        check("R3 miss next page", {15'b0, h}, 16'd0);
        probe(24'h123000, 3'd1, 1'b0, h, i, e);
        check("R4 fc compare mismatch", {15'b0, h}, 16'd0);
        rd(24'h000010, 3'd5, d);  check("R2 rdata zero unselected", d, 16'h0000);
    endtask

    task automatic t_cfc_off();
        logic h, i, e;
        wr(24'h0000F2, 3'd5, 16'h0123, 1'b1, 1'b1);
        probe(24'h123000, 3'd1, 1'b0, h, i, e);
        check("R4 fc ignored (fc1)", {15'b0, h}, 16'd1);
        probe(24'h123FFE, 3'd6, 1'b0, h, i, e);
        check("R4 fc ignored (fc6)", {15'b0, h}, 16'd1);
        probe(24'h123000, 3'd7, 1'b0, h, i, e);
        check("R5 iack never hits", {15'b0, h}, 16'd0);
    endtask

    task automatic t_space();
        logic [15:0] d; logic c, i;
        wr(24'h0000F2, 3'd1, 16'h0456, 1'b1, 1'b1);
        rd(24'h0000F2, 3'd5, d);  check("R2 user write ignored", d, 16'h0123);
        rd(24'h0000F2, 3'd1, d);  check("R2 user read no data", d, 16'h0000);
        @(negedge clk);
        bus_valid = 1'b1; bus_rnw = 1'b1; bus_addr = 24'h0000F2; bus_fc = 3'd5;
        #1 c = cs_inhibit; i = int_access;
        check("R7 cs_inhibit on register", {15'b0, c}, 16'd1);
        check("R7 iac on register", {15'b0, i}, 16'd1);
        idle();
        @(negedge clk);
        bus_valid = 1'b1; bus_addr = 24'h123000; bus_fc = 3'd5;
        #1 c = cs_inhibit;
        check("R7 no inhibit on window", {15'b0, c}, 16'd0);
        idle();
    endtask

    task automatic t_soft_reset();
        logic [15:0] d; logic h, i, e;
        @(negedge clk);
        rst_in = 1'b1; halt_in = 1'b0;
        @(posedge clk);
        idle();
        rd(24'h0000F2, 3'd5, d);  check("R1 reset alone keeps bar", d, 16'h0123);
        probe(24'h123000, 3'd2, 1'b0, h, i, e);
        check("R1 reset alone keeps open", {15'b0, h}, 16'd1);
    endtask

    task automatic t_narrow();
        logic [15:0] d; logic h, i, e;
        total_reset();
        narrow_bus = 1'b1;
        wr(24'h0000F2, 3'd5, 16'hA200, 1'b1, 1'b0);
        rd(24'h0000F2, 3'd5, d);  check("R2 high lane only", d, 16'hA2FF);
        probe(24'h2FF000, 3'd5, 1'b0, h, i, e);
        check("R6 narrow closed after high byte", {15'b0, h}, 16'd0);
        wr(24'h0000F3, 3'd5, 16'h0034, 1'b0, 1'b1);
        probe(24'h234800, 3'd5, 1'b0, h, i, e);
        check("R6 narrow open after low byte", {15'b0, h}, 16'd1);
        narrow_bus = 1'b0;
    endtask

    task automatic t_conflict();
        logic [15:0] d; logic h, i, e;
        probe(24'h234000, 3'd5, 1'b1, h, i, e);
        check("R9 no berr when disabled", {15'b0, e}, 16'd0);
        rd(24'h0000F4, 3'd5, d);  check("R8 flag set", d, 16'h0001);
        wr(24'h0000F4, 3'd5, 16'h0000, 1'b1, 1'b1);
        rd(24'h0000F4, 3'd5, d);  check("R8 flag sticky on zero write", d, 16'h0001);
        wr(24'h0000F4, 3'd5, 16'h0001, 1'b1, 1'b1);
        rd(24'h0000F4, 3'd5, d);  check("R8 flag cleared", d, 16'h0000);
        wr(24'h0000F4, 3'd5, 16'h0002, 1'b1, 1'b1);
        probe(24'h234000, 3'd5, 1'b1, h, i, e);
        check("R9 berr when enabled", {15'b0, e}, 16'd1);
        probe(24'h234000, 3'd5, 1'b0, h, i, e);
        check("R9 no berr without ext_sel", {15'b0, e}, 16'd0);
        rd(24'h0000F4, 3'd5, d);  check("R8 R9 ctl state", d, 16'h0003);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_wide();
                t_cfc_off();
                t_space();
                t_soft_reset();
                t_narrow();
                t_conflict();
            end
            begin
                repeat (5000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule